// File: doc/BRIEF.md
# Free-Running 64-bit Cycle Counter with Torn-Read Detection

This block keeps a wide cycle counter that advances by one on every clock while it is enabled. It wraps silently at the top of its range. Software on a 32-bit auxiliary register bus sees three registers: a control/status word, the low half of the count and the high half.

To read the count, software fetches the low half, then the high half, then the control word. The low-half read also captures the whole count into a snapshot, and the high-half read returns the upper part of that snapshot. The control word reports in its top bit whether the two half reads formed an intact pair since the previous control read. If the bit is clear, software repeats the three reads.

Enabling and disabling the counter is done by writing bit 0 of the control word. The counter keeps its value while it is disabled. Read data is combinational and valid in the same cycle as the read strobe. Any side effect of a read takes effect at the closing clock edge.

Top module: `cycle_stamp_ctr`

## Requirements
- R1: After reset the count, the enable flag, the snapshot and the pair tracking are all zero, so every mapped register reads 0.
- R2: A write to the control address (0x103) loads the enable flag from write bit 0. Control bit 0 reads back that flag.
- R3: While enabled, the count rises by exactly one per clock. While disabled, the count does not change.
- R4: The count wraps from all ones to zero, modulo 2^CNT_W.
- R5: A read of the low address (0x104) returns the current low half of the count and stores the full count into the snapshot at that edge.
- R6: A read of the high address (0x105) returns the upper half of the most recent snapshot, which is zero before any low read.
- R7: Control bit DATA_W-1 (bit 31) reads 1 only if, since the last control read, a low read was followed by a high read with no other low read after it. Control bits 30..1 read 0.
- R8: Every control read clears the pair tracking, so a second control read with no half reads in between shows bit 31 as 0.
- R9: Writes to the low or high address have no effect. Reads of any unmapped address return 0 and change no state.
- R10: Read data for a register is valid in the same cycle as its read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aux_addr | input | 12 | Register address |
| aux_rd | input | 1 | Read strobe, one cycle per access |
| aux_wr | input | 1 | Write strobe, one cycle per access |
| aux_wdata | input | 32 | Write data |
| aux_rdata | output | 32 | Read data, combinational |

## Verification
The embedded properties check on every cycle that the counter steps by one or holds according to the enable flag, including across the wrap. They also check that a low read loads the snapshot with the upper half of the live count, that a low read followed by a high read arms the pair flag, and that a control read always clears the tracking. What only the bench's scenarios can show is the software-visible picture: that the three-read sequence returns the expected numbers, and that interleavings such as a repeated low read, a lone high read or a repeated control read report a torn pair. They also show that writes to read-only addresses leave the count alone and that the narrow configuration really wraps.

// File: rtl/cyc_ctr_pkg.sv
package cyc_ctr_pkg;

   // Pair-tracking progress since the last control read
   typedef enum logic [1:0] {
      TRK_IDLE    = 2'd0,
      TRK_GOT_LO  = 2'd1,
      TRK_PAIR_OK = 2'd2
   } trk_state_t;

   // Decoded register access of one cycle
   typedef struct packed {
      logic rd_ctrl;
      logic rd_lo;
      logic rd_hi;
      logic wr_ctrl;
   } acc_sel_t;

endpackage

// File: rtl/cyc_aux_decode.sv
module cyc_aux_decode
   import cyc_ctr_pkg::*;
#(
   parameter int                ADDR_W    = 12,
   parameter logic [ADDR_W-1:0] ADR_CTRL  = 12'h103,
   parameter logic [ADDR_W-1:0] ADR_LO    = 12'h104,
   parameter logic [ADDR_W-1:0] ADR_HI    = 12'h105
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   output acc_sel_t          sel
);

   generate
      if (ADR_CTRL == ADR_LO || ADR_CTRL == ADR_HI || ADR_LO == ADR_HI) begin : g_adr_clash
         $error("cyc_aux_decode: register addresses must be distinct");
      end
   endgenerate

   always_comb begin
      sel         = '0;
      sel.rd_ctrl = rd && (addr == ADR_CTRL);
      sel.rd_lo   = rd && (addr == ADR_LO);
      sel.rd_hi   = rd && (addr == ADR_HI);
      sel.wr_ctrl = wr && (addr == ADR_CTRL);
   end

   // R9
   rd_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel.rd_ctrl, sel.rd_lo, sel.rd_hi}));

endmodule

// File: rtl/cyc_count_core.sv
module cyc_count_core #(
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 64,
   parameter bit SPLIT_ADD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             en_in,
   output logic             en_q,
   output logic [CNT_W-1:0] cnt_q
);

   localparam int HALF_W = CNT_W / 2;

   logic [CNT_W-1:0] cnt_nx;

   generate
      if (CNT_W != 2 * DATA_W) begin : g_bad_w
         $error("cyc_count_core: CNT_W must be twice DATA_W");
      end
      if (SPLIT_ADD) begin : g_split
         // Low half increments alone; its all-ones state forwards a carry
         logic           lo_full;
         logic [HALF_W-1:0] lo_nx;
         logic [HALF_W-1:0] hi_nx;
         always_comb begin
            lo_full = &cnt_q[HALF_W-1:0];
            lo_nx   = cnt_q[HALF_W-1:0] + 1'b1;
            hi_nx   = cnt_q[CNT_W-1:HALF_W] + {{(HALF_W-1){1'b0}}, lo_full};
            cnt_nx  = {hi_nx, lo_nx};
         end
      end else begin : g_flat
         always_comb cnt_nx = cnt_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         cnt_q <= '0;
      end else begin
         if (wr_en) en_q <= en_in;
         if (en_q)  cnt_q <= cnt_nx;
      end
   end

   // R3 R4
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> cnt_q == $past(cnt_q) + 1'b1);

   // R3
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> $stable(cnt_q));

   // R2
   en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> en_q == $past(en_in));

endmodule

// File: rtl/cyc_snap_track.sv
module cyc_snap_track
   import cyc_ctr_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  acc_sel_t          sel,
   input  logic [DATA_W-1:0] cnt_hi,
   output logic [DATA_W-1:0] snap_hi,
   output logic              pair_ok
);

   trk_state_t st_q, st_nx;

   always_comb begin
      st_nx = st_q;
      if (sel.rd_ctrl)                          st_nx = TRK_IDLE;
      else if (sel.rd_lo)                       st_nx = TRK_GOT_LO;
      else if (sel.rd_hi && st_q == TRK_GOT_LO) st_nx = TRK_PAIR_OK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= TRK_IDLE;
         snap_hi <= '0;
      end else begin
         st_q <= st_nx;
         if (sel.rd_lo) snap_hi <= cnt_hi;
      end
   end

   assign pair_ok = (st_q == TRK_PAIR_OK);

   // R5
   snap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel.rd_lo |=> snap_hi == $past(cnt_hi));

   // R7
   pair_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel.rd_hi && !sel.rd_lo && !sel.rd_ctrl && st_q == TRK_GOT_LO) |=> pair_ok);

   // R8
   ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel.rd_ctrl |=> !pair_ok);

   // R6
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel.rd_lo |=> $stable(snap_hi));

endmodule

// File: rtl/cycle_stamp_ctr.sv
module cycle_stamp_ctr
   import cyc_ctr_pkg::*;
#(
   parameter int                ADDR_W    = 12,
   parameter int                DATA_W    = 32,
   parameter int                CNT_W     = 2 * DATA_W,
   parameter bit                SPLIT_ADD = 1'b1,
   parameter logic [ADDR_W-1:0] ADR_CTRL  = 12'h103,
   parameter logic [ADDR_W-1:0] ADR_LO    = 12'h104,
   parameter logic [ADDR_W-1:0] ADR_HI    = 12'h105
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] aux_addr,
   input  logic              aux_rd,
   input  logic              aux_wr,
   input  logic [DATA_W-1:0] aux_wdata,
   output logic [DATA_W-1:0] aux_rdata
);

   localparam int VLD_BIT = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_dw
         $error("cycle_stamp_ctr: DATA_W must be at least 2");
      end
   endgenerate

   acc_sel_t          sel;
   logic              en_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] snap_hi;
   logic              pair_ok;

   cyc_aux_decode #(
      .ADDR_W   (ADDR_W),
      .ADR_CTRL (ADR_CTRL),
      .ADR_LO   (ADR_LO),
      .ADR_HI   (ADR_HI)
   ) u_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (aux_addr),
      .rd    (aux_rd),
      .wr    (aux_wr),
      .sel   (sel)
   );

   cyc_count_core #(
      .DATA_W    (DATA_W),
      .CNT_W     (CNT_W),
      .SPLIT_ADD (SPLIT_ADD)
   ) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (sel.wr_ctrl),
      .en_in (aux_wdata[0]),
      .en_q  (en_q),
      .cnt_q (cnt_q)
   );

   cyc_snap_track #(
      .DATA_W (DATA_W)
   ) u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel),
      .cnt_hi  (cnt_q[CNT_W-1:DATA_W]),
      .snap_hi (snap_hi),
      .pair_ok (pair_ok)
   );

   always_comb begin
      aux_rdata = '0;
      if (sel.rd_ctrl) begin
         aux_rdata[0]       = en_q;
         aux_rdata[VLD_BIT] = pair_ok;
      end else if (sel.rd_lo) begin
         aux_rdata = cnt_q[DATA_W-1:0];
      end else if (sel.rd_hi) begin
         aux_rdata = snap_hi;
      end
   end

   // R9
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !aux_rd |-> aux_rdata == '0);

endmodule

// File: tb/tb_cycle_stamp_ctr.sv
module tb_cycle_stamp_ctr;

   localparam logic [11:0] A_CTRL = 12'h103;
   localparam logic [11:0] A_LO   = 12'h104;
   localparam logic [11:0] A_HI   = 12'h105;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] aux_addr = '0;
   logic        aux_rd = 1'b0;
   logic        aux_wr = 1'b0;
   logic [31:0] aux_wdata = '0;
   logic [31:0] aux_rdata;

   logic [11:0] s_addr = '0;
   logic        s_rd = 1'b0;
   logic        s_wr = 1'b0;
   logic [3:0]  s_wdata = '0;
   logic [3:0]  s_rdata;

   always #2 clk = ~clk;

   cycle_stamp_ctr dut (
      .clk(clk), .rst_n(rst_n), .aux_addr(aux_addr), .aux_rd(aux_rd),
      .aux_wr(aux_wr), .aux_wdata(aux_wdata), .aux_rdata(aux_rdata));

   cycle_stamp_ctr #(.DATA_W(4), .SPLIT_ADD(1'b0)) dut_small (
      .clk(clk), .rst_n(rst_n), .aux_addr(s_addr), .aux_rd(s_rd),
      .aux_wr(s_wr), .aux_wdata(s_wdata), .aux_rdata(s_rdata));

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // Reference model
   logic [63:0] m_cnt = '0;
   logic [31:0] m_snap = '0;
   logic        m_en = 1'b0;
   int          m_st = 0;   // 0 idle, 1 low seen, 2 pair ok

   function automatic logic [31:0] exp_read(logic [11:0] a);
      if (a == A_LO)   return m_cnt[31:0];
      if (a == A_HI)   return m_snap;
      if (a == A_CTRL) return {(m_st == 2), 30'b0, m_en};
      return 32'h0;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Called at a negedge; returns at the following negedge
   task automatic do_read(logic [11:0] a, string tag);
      logic [31:0] e;
      e = exp_read(a);
      aux_addr = a; aux_rd = 1'b1;
      #1 check(tag, aux_rdata, e);
      @(negedge clk);
      aux_rd = 1'b0;
      if (a == A_LO) begin m_snap = m_cnt[63:32]; m_st = 1; end
      else if (a == A_HI) begin if (m_st == 1) m_st = 2; end
      else if (a == A_CTRL) m_st = 0;
      if (m_en) m_cnt++;
   endtask

   task automatic do_write(logic [11:0] a, logic [31:0] d);
      logic en_old;
      en_old = m_en;
      aux_addr = a; aux_wdata = d; aux_wr = 1'b1;
      @(negedge clk);
      aux_wr = 1'b0;
      if (a == A_CTRL) m_en = d[0];
      if (en_old) m_cnt++;
   endtask

   task automatic do_idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (m_en) m_cnt++;
      end
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] lo1;
      logic [31:0] lo2;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, R6 snapshot zero before any low read, R10 same-cycle data
      do_read(A_CTRL, "R1 ctrl after reset");
      do_read(A_HI,   "R6 high before low read");
      do_read(A_LO,   "R1 R10 low after reset");
      // R3 disabled count holds
      do_idle(5);
      do_read(A_LO,   "R3 hold while disabled");
      do_read(A_CTRL, "R8 clear");

      // R2 enable via bit 0
      do_write(A_CTRL, 32'hFFFF_FFF1);
      do_read(A_CTRL, "R2 enable readback");

      // R5 R6 R7 intact sequence
      do_read(A_LO,   "R5 low word");
      do_read(A_HI,   "R6 high word");
      do_read(A_CTRL, "R7 pair intact");
      do_read(A_CTRL, "R8 second ctrl read");

      // R7 torn patterns
      do_read(A_LO, "R5 low a"); do_read(A_LO, "R5 low b");
      do_read(A_CTRL, "R7 low low ctrl");
      do_read(A_HI, "R6 lone high");
      do_read(A_CTRL, "R7 lone high");
      do_read(A_LO, "R5 low c"); do_read(A_HI, "R6 high c"); do_read(A_LO, "R5 low d");
      do_read(A_CTRL, "R7 low high low");
      do_read(A_LO, "R5 low e"); do_read(A_LO, "R5 low f"); do_read(A_HI, "R6 high f");
      do_read(A_CTRL, "R7 low low high");

      // R9 writes to read-only halves ignored, unmapped reads zero
      do_write(A_LO, 32'hFFFF_FFFF);
      do_write(A_HI, 32'hFFFF_FFFF);
      do_read(A_LO, "R9 low after ignored write");
      do_read(12'h050, "R9 unmapped read");
      do_read(A_HI, "R9 high after ignored write");

      // R3 disable then hold
      do_write(A_CTRL, 32'h0);
      lo1 = m_cnt[31:0];
      do_read(A_LO, "R3 low at disable");
      do_idle(7);
      lo2 = m_cnt[31:0];
      check("R3 model hold", lo2, lo1);
      do_read(A_LO, "R3 low after idle");
      do_read(A_CTRL, "R2 disabled readback");

      // Random mix
      do_write(A_CTRL, 32'h1);
      for (int k = 0; k < 3000; k++) begin
         int op;
         op = $urandom_range(0, 9);
         case (op)
            0:       do_idle(1 + $urandom_range(0, 3));
            1, 2:    do_read(A_LO,   "R5 random low");
            3, 4:    do_read(A_HI,   "R6 random high");
            5, 6:    do_read(A_CTRL, "R7 random ctrl");
            7:       do_write(A_CTRL, (($urandom_range(0, 7) != 0) ? 32'h1 : 32'h0));
            8:       do_write(($urandom_range(0, 1) != 0) ? A_LO : A_HI, $urandom());
            default: do_read(12'(($urandom_range(0, 255))), "R9 random addr");
         endcase
      end

      // R4 wrap on the narrow instance: 299 steps wrap past 256
      s_addr = A_CTRL; s_wdata = 4'h1; s_wr = 1'b1;
      @(negedge clk);
      s_wr = 1'b0;
      repeat (299) @(negedge clk);
      s_addr = A_LO; s_rd = 1'b1;
      #1 check("R4 wrapped low nibble", {28'b0, s_rdata}, 32'(299 % 256 % 16));
      @(negedge clk);
      s_addr = A_HI;
      #1 check("R4 wrapped high nibble", {28'b0, s_rdata}, 32'((299 % 256) / 16));
      @(negedge clk);
      s_addr = A_CTRL;
      #1 check("R7 narrow pair bit", {28'b0, s_rdata}, 32'h9);
      @(negedge clk);
      s_rd = 1'b0;

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule